// File: doc/BRIEF.md
# Page-granular compartment memory firewall

This block sits between a bus initiator and a small on-chip memory of up to 32 pages of 4 KB each. It judges every access in the same cycle it is presented. The judgement uses the page the address falls in, the secure and privileged attributes of the access, and the compartment identifier (CID) of the initiator. Allowed accesses pass through to the memory port unchanged. A denied access never reaches the memory: it returns all-zero read data and raises an error response. A denied write is therefore dropped.

The protection state lives in a word-addressed configuration register file that only secure initiators may use. The per-page state is a security bit, a default-privilege bit and a CID filter setting. The per-CID state is a read bitmap, a write bitmap and a privilege bitmap, each holding one bit per page. A global control bit lets secure initiators reach non-secure pages. A two-state capture machine records the first denied access: its address and its attributes (read or write, CID, secure, privileged). The machine then holds that record until software clears the flag. The states are CAP_IDLE and CAP_HELD. CAP_IDLE moves to CAP_HELD on a denial. CAP_HELD returns to CAP_IDLE when the data-fault flag is cleared and no new denial arrives in that cycle. CAP_HELD stays in CAP_HELD and takes a fresh record when a clear and a denial arrive in the same cycle. A level interrupt is high while any status flag is set.

Top module: `page_fw`

## Requirements
- R1: The page index is access address bits [16:12]. Without CID filtering on a page, an access is allowed only if two things hold. Its secure bit matches the page's security attribute, subject to R2. If the page's default-privilege attribute is set, the access is privileged.
- R2: Control register 0x000 bit 31 set lets a secure access reach a non-secure page. A non-secure access to a secure page is always denied. With the bit clear, the security attributes must match exactly.
- R3: When the page's CID filter is enabled (bit 0 of register 0xA00+4*page), a read needs the page bit set in the read bitmap of the access CID. A write needs the page bit set in that CID's write bitmap. The read bitmap of CID x is at 0x808+0x20*x and the write bitmap at 0x810+0x20*x, with bit n for page n. The security match of R1/R2 still applies.
- R4: Under CID filtering, if the page bit is set in the access CID's privilege bitmap (0x800+0x20*x), an unprivileged access is denied. The default-privilege attribute is not consulted.
- R5: Under CID filtering, an access carrying CID 7 is always denied, because only CIDs 0 to 6 exist.
- R6: A denied access keeps mem_req low, returns acc_rdata = 0 and raises acc_err in the same cycle. An allowed access raises mem_req and returns mem_rdata.
- R7: The first denied access sets status bit 1 (register 0x008). It also captures the address in 0x024 and the attributes in 0x020, encoded as bit 0 write, bit 1 secure, bit 2 privileged and bits 6:4 CID. Later denials leave the capture unchanged while the flag is set.
- R8: Writing 1 to bit 0 or bit 1 of 0x00C clears the matching status bit. irq is high exactly while a status bit is set.
- R9: After reset every configuration register, the status, the capture registers and irq are zero.
- R10: The security (0x100+4*page) and privilege (0x200+4*page) registers take bit 0 of the written data and read back 0xFF or 0x00. The CID register keeps only bits 0, 2 and 6:4. The control register keeps only bit 31. All other bits read as zero.
- R11: A configuration access with cfg_sec low is ignored: a write changes nothing and a read returns zero. Either one sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_sec | input | 1 | Configuration access is secure |
| cfg_addr | input | 12 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, same cycle |
| acc_req | input | 1 | Data access request |
| acc_we | input | 1 | Data access is a write |
| acc_addr | input | 17 | Data byte address within the window |
| acc_wdata | input | 32 | Data write value |
| acc_cid | input | 3 | Initiator compartment ID |
| acc_sec | input | 1 | Access is secure |
| acc_priv | input | 1 | Access is privileged |
| acc_rdata | output | 32 | Read data, zero when denied |
| acc_err | output | 1 | Access denied |
| mem_req | output | 1 | Request forwarded to memory |
| mem_we | output | 1 | Write forwarded to memory |
| mem_addr | output | 17 | Address forwarded to memory |
| mem_wdata | output | 32 | Write data forwarded to memory |
| mem_rdata | input | 32 | Read data from memory |
| irq | output | 1 | Level interrupt while any status flag is set |

## Verification
The bench checks that a secure access to a non-secure page is refused until the control bit is set. It also checks that a non-secure access to a secure page stays refused afterwards. A design with a symmetric security check would let the non-secure access through. It tests a CID whose privilege bitmap marks a page, using an unprivileged read. Such a read must fail even though the read bitmap grants it, and a design that ignores the privilege bitmap would accept it. A CID of 7 on a filtered page must be refused, where an unguarded index would read a stray bitmap. The bench causes a second denial while the capture is held and expects the first address to remain, where an overwriting design would show the newer one. Random mixes of CID, security, privilege and direction are compared against a bench-side permission model.

// File: rtl/fw_pkg.sv
package fw_pkg;
    localparam int CID_N = 7;
    localparam int CID_W = 3;
    localparam int PAGE_LSB = 12;

    typedef enum logic {CAP_IDLE, CAP_HELD} cap_state_t;

    // fault attribute word layout
    typedef struct packed {
        logic [24:0] zero;
        logic [2:0]  cid;
        logic        pad;
        logic        priv;
        logic        sec;
        logic        wr;
    } fault_attr_t;

    localparam logic [3:0] GRP_GLOBAL = 4'h0;
    localparam logic [3:0] GRP_SEC    = 4'h1;
    localparam logic [3:0] GRP_PRIV   = 4'h2;
    localparam logic [3:0] GRP_CIDMAP = 4'h8;
    localparam logic [3:0] GRP_CIDCFG = 4'hA;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_STAT  = 8'h08;
    localparam logic [7:0] OFS_CLR   = 8'h0C;
    localparam logic [7:0] OFS_ATTR  = 8'h20;
    localparam logic [7:0] OFS_FADDR = 8'h24;

    localparam logic [2:0] MAP_PRIV = 3'd0;
    localparam logic [2:0] MAP_RD   = 3'd2;
    localparam logic [2:0] MAP_WR   = 3'd4;
endpackage

// File: rtl/fw_regfile.sv
module fw_regfile
    import fw_pkg::*;
#(
    parameter int NPAGES = 32,                 // at most 32
    localparam int PG_W = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic                          cfg_re,
    input  logic                          cfg_sec,
    input  logic [11:0]                   cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic [31:0]                   cfg_rdata,
    output logic                          cfg_fault,
    output logic                          clr_cfg,
    output logic                          clr_ia,
    input  logic [1:0]                    flags,
    input  logic [31:0]                   fault_attr,
    input  logic [31:0]                   fault_addr,
    output logic                          srwiad,
    output logic [NPAGES-1:0]             pg_sec,
    output logic [NPAGES-1:0]             pg_priv,
    output logic [NPAGES-1:0]             pg_cfen,
    output logic [CID_N-1:0][NPAGES-1:0]  map_rd,
    output logic [CID_N-1:0][NPAGES-1:0]  map_wr,
    output logic [CID_N-1:0][NPAGES-1:0]  map_pv
);
    logic                   wr_ok;
    logic                   rd_ok;
    logic [3:0]             grp;
    logic [7:0]             ofs;
    logic [5:0]             slot;
    logic                   slot_ok;
    logic [PG_W-1:0]        pidx;
    logic [2:0]             cid_sel;
    logic [2:0]             kind;
    logic                   cid_ok;
    logic                   aligned;

    logic [NPAGES-1:0]      dcen_q;
    logic [NPAGES-1:0][2:0] ddcid_q;

    assign wr_ok   = cfg_we & cfg_sec;
    assign rd_ok   = cfg_re & cfg_sec;
    assign grp     = cfg_addr[11:8];
    assign ofs     = cfg_addr[7:0];
    assign slot    = cfg_addr[7:2];
    assign aligned = (cfg_addr[1:0] == 2'b00);
    assign slot_ok = aligned && (int'(slot) < NPAGES);
    assign pidx    = slot[PG_W-1:0];
    assign cid_sel = cfg_addr[7:5];
    assign kind    = cfg_addr[4:2];
    assign cid_ok  = aligned && (int'(cid_sel) < CID_N);

    assign cfg_fault = (cfg_we | cfg_re) & ~cfg_sec;
    assign clr_cfg   = wr_ok && grp == GRP_GLOBAL && ofs == OFS_CLR && cfg_wdata[0];
    assign clr_ia    = wr_ok && grp == GRP_GLOBAL && ofs == OFS_CLR && cfg_wdata[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srwiad  <= 1'b0;
            pg_sec  <= '0;
            pg_priv <= '0;
            pg_cfen <= '0;
            dcen_q  <= '0;
            ddcid_q <= '0;
            map_rd  <= '0;
            map_wr  <= '0;
            map_pv  <= '0;
        end else if (wr_ok) begin
            case (grp)
                GRP_GLOBAL: if (ofs == OFS_CTRL) srwiad <= cfg_wdata[31];
                GRP_SEC:    if (slot_ok) pg_sec[pidx]  <= cfg_wdata[0];
                GRP_PRIV:   if (slot_ok) pg_priv[pidx] <= cfg_wdata[0];
                GRP_CIDMAP: if (cid_ok) begin
                    case (kind)
                        MAP_PRIV: map_pv[cid_sel] <= cfg_wdata[NPAGES-1:0];
                        MAP_RD:   map_rd[cid_sel] <= cfg_wdata[NPAGES-1:0];
                        MAP_WR:   map_wr[cid_sel] <= cfg_wdata[NPAGES-1:0];
                        default: ;
                    endcase
                end
                GRP_CIDCFG: if (slot_ok) begin
                    pg_cfen[pidx] <= cfg_wdata[0];
                    dcen_q[pidx]  <= cfg_wdata[2];
                    ddcid_q[pidx] <= cfg_wdata[6:4];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (rd_ok) begin
            case (grp)
                GRP_GLOBAL: begin
                    case (ofs)
                        OFS_CTRL:  cfg_rdata[31]  = srwiad;
                        OFS_STAT:  cfg_rdata[1:0] = flags;
                        OFS_ATTR:  cfg_rdata      = fault_attr;
                        OFS_FADDR: cfg_rdata      = fault_addr;
                        default: ;
                    endcase
                end
                GRP_SEC:  if (slot_ok) cfg_rdata[7:0] = {8{pg_sec[pidx]}};
                GRP_PRIV: if (slot_ok) cfg_rdata[7:0] = {8{pg_priv[pidx]}};
                GRP_CIDMAP: if (cid_ok) begin
                    case (kind)
                        MAP_PRIV: cfg_rdata[NPAGES-1:0] = map_pv[cid_sel];
                        MAP_RD:   cfg_rdata[NPAGES-1:0] = map_rd[cid_sel];
                        MAP_WR:   cfg_rdata[NPAGES-1:0] = map_wr[cid_sel];
                        default: ;
                    endcase
                end
                GRP_CIDCFG: if (slot_ok)
                    cfg_rdata = {25'b0, ddcid_q[pidx], 1'b0, dcen_q[pidx], 1'b0, pg_cfen[pidx]};
                default: ;
            endcase
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;
endmodule

// File: rtl/fw_perm_check.sv
module fw_perm_check
    import fw_pkg::*;
#(
    parameter int NPAGES = 32,
    localparam int PG_W = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
    input  logic [PG_W-1:0]               page,
    input  logic                          is_wr,
    input  logic [CID_W-1:0]              cid,
    input  logic                          sec,
    input  logic                          priv,
    input  logic                          srwiad,
    input  logic [NPAGES-1:0]             pg_sec,
    input  logic [NPAGES-1:0]             pg_priv,
    input  logic [NPAGES-1:0]             pg_cfen,
    input  logic [CID_N-1:0][NPAGES-1:0]  map_rd,
    input  logic [CID_N-1:0][NPAGES-1:0]  map_wr,
    input  logic [CID_N-1:0][NPAGES-1:0]  map_pv,
    output logic                          allow
);
    logic in_range;
    logic cid_ok;
    logic page_s;
    logic sec_ok;
    logic base_ok;
    logic cid_rw_ok;
    logic cid_pv_ok;

    // per-CID view of the addressed page, one bit per CID
    logic [CID_N-1:0] rd_bits;
    logic [CID_N-1:0] wr_bits;
    logic [CID_N-1:0] pv_bits;

    assign in_range = int'(page) < NPAGES;
    assign cid_ok   = int'(cid) < CID_N;
    assign page_s   = pg_sec[page];

    for (genvar c = 0; c < CID_N; c++) begin : g_cid
        assign rd_bits[c] = map_rd[c][page];
        assign wr_bits[c] = map_wr[c][page];
        assign pv_bits[c] = map_pv[c][page];
    end

    always_comb begin
        sec_ok    = (sec == page_s) || (sec && !page_s && srwiad);
        base_ok   = !pg_priv[page] || priv;
        cid_rw_ok = 1'b0;
        cid_pv_ok = 1'b0;
        if (cid_ok) begin
            cid_rw_ok = is_wr ? wr_bits[cid] : rd_bits[cid];
            cid_pv_ok = !pv_bits[cid] || priv;
        end
        if (!in_range)
            allow = 1'b0;
        else if (pg_cfen[page])
            allow = sec_ok && cid_rw_ok && cid_pv_ok;
        else
            allow = sec_ok && base_ok;
    end
endmodule

// File: rtl/fw_err_capture.sv
module fw_err_capture
    import fw_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deny,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_wr,
    input  logic [CID_W-1:0]  cid,
    input  logic              sec,
    input  logic              priv,
    input  logic              cfg_fault,
    input  logic              clr_cfg,
    input  logic              clr_ia,
    output logic [1:0]        flags,
    output logic [31:0]       fault_attr,
    output logic [31:0]       fault_addr,
    output logic              irq
);
    cap_state_t  state_q, state_d;
    logic        take;
    logic        cfg_flag_q;
    fault_attr_t attr_q;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            CAP_IDLE: if (deny) begin
                state_d = CAP_HELD;
                take    = 1'b1;
            end
            CAP_HELD: if (clr_ia) begin
                state_d = deny ? CAP_HELD : CAP_IDLE;
                take    = deny;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attr_q     <= '0;
            addr_q     <= '0;
            cfg_flag_q <= 1'b0;
        end else begin
            if (take) begin
                attr_q      <= '0;
                attr_q.cid  <= cid;
                attr_q.priv <= priv;
                attr_q.sec  <= sec;
                attr_q.wr   <= is_wr;
                addr_q      <= addr;
            end
            if (cfg_fault)    cfg_flag_q <= 1'b1;
            else if (clr_cfg) cfg_flag_q <= 1'b0;
        end
    end

    always_comb begin
        flags      = {state_q == CAP_HELD, cfg_flag_q};
        fault_attr = attr_q;
        fault_addr = {{(32-ADDR_W){1'b0}}, addr_q};
        irq        = |flags;
    end
endmodule

// File: rtl/page_fw.sv
module page_fw
    import fw_pkg::*;
#(
    parameter int NPAGES = 32,
    parameter int DATA_W = 32,
    localparam int PG_W = (NPAGES > 1) ? $clog2(NPAGES) : 1,
    localparam int ADDR_W = PG_W + PAGE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_re,
    input  logic              cfg_sec,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [CID_W-1:0]  acc_cid,
    input  logic              acc_sec,
    input  logic              acc_priv,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq
);
    logic                          srwiad;
    logic [NPAGES-1:0]             pg_sec, pg_priv, pg_cfen;
    logic [CID_N-1:0][NPAGES-1:0]  map_rd, map_wr, map_pv;
    logic                          cfg_fault, clr_cfg, clr_ia;
    logic [1:0]                    flags;
    logic [31:0]                   fault_attr, fault_addr;
    logic                          allow;
    logic                          deny;

    fw_regfile #(.NPAGES(NPAGES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sec(cfg_sec),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_fault(cfg_fault), .clr_cfg(clr_cfg), .clr_ia(clr_ia),
        .flags(flags), .fault_attr(fault_attr), .fault_addr(fault_addr),
        .srwiad(srwiad), .pg_sec(pg_sec), .pg_priv(pg_priv), .pg_cfen(pg_cfen),
        .map_rd(map_rd), .map_wr(map_wr), .map_pv(map_pv)
    );

    fw_perm_check #(.NPAGES(NPAGES)) u_perm (
        .page(acc_addr[ADDR_W-1:PAGE_LSB]), .is_wr(acc_we), .cid(acc_cid),
        .sec(acc_sec), .priv(acc_priv), .srwiad(srwiad),
        .pg_sec(pg_sec), .pg_priv(pg_priv), .pg_cfen(pg_cfen),
        .map_rd(map_rd), .map_wr(map_wr), .map_pv(map_pv),
        .allow(allow)
    );

    assign deny = acc_req & ~allow;

    fw_err_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .deny(deny), .addr(acc_addr),
        .is_wr(acc_we), .cid(acc_cid), .sec(acc_sec), .priv(acc_priv),
        .cfg_fault(cfg_fault), .clr_cfg(clr_cfg), .clr_ia(clr_ia),
        .flags(flags), .fault_attr(fault_attr), .fault_addr(fault_addr),
        .irq(irq)
    );

    assign mem_req   = acc_req & allow;
    assign mem_we    = acc_we;
    assign mem_addr  = acc_addr;
    assign mem_wdata = acc_wdata;
    assign acc_rdata = allow ? mem_rdata : '0;
    assign acc_err   = deny;
endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_re,
    input logic              cfg_sec,
    input logic [11:0]       cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              acc_req,
    input logic              acc_err,
    input logic [DATA_W-1:0] acc_rdata,
    input logic              mem_req,
    input logic [1:0]        flags,
    input logic [31:0]       fault_addr
);
    p_deny_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_err) |-> (!mem_req && acc_rdata == '0));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req |-> (!acc_err && !mem_req));

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_err) |=> flags[1]);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !(cfg_we && cfg_sec && cfg_addr == 12'h00C && cfg_wdata[1]))
        |=> $stable(fault_addr));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sec && cfg_addr == 12'h00C && cfg_wdata[1] && !(acc_req && acc_err))
        |=> !flags[1]);

    p_cfg_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_we || cfg_re) && !cfg_sec) |=> flags[0]);
endmodule

bind page_fw fw_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sec(cfg_sec),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_req(acc_req), .acc_err(acc_err), .acc_rdata(acc_rdata),
    .mem_req(mem_req), .flags(flags), .fault_addr(fault_addr)
);

// File: tb/page_fw_test.sv
module page_fw_test;
    localparam int AW = 17;
    localparam logic [31:0] MEMV = 32'hCAFE_F00D;
    localparam int NV = 12;
    // {cid[3], sec, priv, we, page[5], allowed}
    localparam logic [11:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1},
        {3'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0},
        {3'd5, 1'b1, 1'b1, 1'b1, 5'd1, 1'b1},
        {3'd5, 1'b1, 1'b0, 1'b0, 5'd1, 1'b0},
        {3'd5, 1'b0, 1'b1, 1'b0, 5'd1, 1'b0},
        {3'd1, 1'b0, 1'b1, 1'b0, 5'd2, 1'b1},
        {3'd1, 1'b0, 1'b0, 1'b0, 5'd2, 1'b0},
        {3'd1, 1'b0, 1'b1, 1'b1, 5'd2, 1'b0},
        {3'd2, 1'b0, 1'b0, 1'b1, 5'd2, 1'b1},
        {3'd2, 1'b0, 1'b0, 1'b0, 5'd2, 1'b0},
        {3'd3, 1'b1, 1'b0, 1'b1, 5'd3, 1'b1},
        {3'd7, 1'b1, 1'b1, 1'b0, 5'd3, 1'b0}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_we = 0, cfg_re = 0, cfg_sec = 0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic acc_req = 0, acc_we = 0, acc_sec = 0, acc_priv = 0;
    logic [AW-1:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [2:0] acc_cid = '0;
    logic [31:0] acc_rdata;
    logic acc_err, mem_req, mem_we, irq;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = MEMV;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [31:0] sec_s = '0, prv_s = '0, cf_s = '0;
    bit [31:0] rd_s [7];
    bit [31:0] wr_s [7];
    bit [31:0] pv_s [7];
    bit srw = 0;

    always #5 clk = ~clk;

    page_fw uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_sec(cfg_sec),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_cid(acc_cid), .acc_sec(acc_sec),
        .acc_priv(acc_priv), .acc_rdata(acc_rdata), .acc_err(acc_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d, input logic s);
        @(negedge clk);
        cfg_we = 1; cfg_sec = s; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0; cfg_sec = 0;
    endtask

    task automatic cfg_rd(input logic [11:0] a, input logic s, output logic [31:0] d);
        @(negedge clk);
        cfg_re = 1; cfg_sec = s; cfg_addr = a;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_re = 0; cfg_sec = 0;
    endtask

    task automatic access(input logic [2:0] c, input logic s, input logic p, input logic w,
                          input logic [AW-1:0] a,
                          output logic e, output logic [31:0] rd, output logic mr);
        @(negedge clk);
        acc_req = 1; acc_cid = c; acc_sec = s; acc_priv = p; acc_we = w; acc_addr = a;
        acc_wdata = 32'h1234_5678;
        #1 e = acc_err; rd = acc_rdata; mr = mem_req;
        @(negedge clk);
        acc_req = 0;
    endtask

    function automatic bit model_ok(int c, bit s, bit p, bit w, int pg);
        bit sec_ok;
        sec_ok = (s == sec_s[pg]) || (s && !sec_s[pg] && srw);
        if (!cf_s[pg]) return sec_ok && (!prv_s[pg] || p);
        if (c >= 7) return 1'b0;
        return sec_ok && (w ? wr_s[c][pg] : rd_s[c][pg]) && (!pv_s[c][pg] || p);
    endfunction

    function automatic string vec_tag(int i);
        int pg;
        pg = int'(VEC[i][5:1]);
        if (VEC[i][11:9] == 3'd7) return "R5 cid7";
        if (pg < 2) return "R1 attr";
        if (i == 6) return "R4 privmap";
        return "R3 bitmap";
    endfunction

    initial begin
        logic [31:0] d;
        logic e, mr;
        logic [31:0] rd;
        for (int i = 0; i < 7; i++) begin rd_s[i] = '0; wr_s[i] = '0; pv_s[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R9: reset state
        #1 chk("R9 irq", {31'b0, irq}, 32'h0);
        cfg_rd(12'h000, 1, d); chk("R9 ctrl", d, 32'h0);
        cfg_rd(12'h008, 1, d); chk("R9 status", d, 32'h0);
        cfg_rd(12'h100, 1, d); chk("R9 sec page0", d, 32'h0);
        cfg_rd(12'h808, 1, d); chk("R9 rdmap cid0", d, 32'h0);
        cfg_rd(12'h024, 1, d); chk("R9 fault addr", d, 32'h0);

        // R11: non-secure configuration access
        cfg_wr(12'h000, 32'h8000_0000, 0);
        cfg_rd(12'h000, 1, d); chk("R11 ns write ignored", d, 32'h0);
        cfg_rd(12'h008, 1, d); chk("R11 cfg flag", d, 32'h1);
        chk("R11 irq", {31'b0, irq}, 32'h1);
        cfg_wr(12'h00C, 32'h1, 1);
        cfg_rd(12'h008, 1, d); chk("R8 clear cfg flag", d, 32'h0);
        cfg_wr(12'h104, 32'h1, 1);
        cfg_rd(12'h104, 0, d); chk("R11 ns read zero", d, 32'h0);
        cfg_wr(12'h00C, 32'h1, 1);
        cfg_rd(12'h104, 1, d); chk("R10 sec reads ff", d, 32'hFF);
        chk("R8 irq low", {31'b0, irq}, 32'h0);

        // R10: reserved bits
        cfg_wr(12'hA7C, 32'hFFFF_FFFF, 1);
        cfg_rd(12'hA7C, 1, d); chk("R10 cidcfg mask", d, 32'h75);
        cfg_wr(12'hA7C, 32'h0, 1);
        cfg_wr(12'h000, 32'hFFFF_FFFF, 1);
        cfg_rd(12'h000, 1, d); chk("R10 ctrl mask", d, 32'h8000_0000);
        cfg_wr(12'h000, 32'h0, 1);

        // configuration
        sec_s[1] = 1; prv_s[1] = 1; cf_s[2] = 1; sec_s[3] = 1; cf_s[3] = 1;
        rd_s[1][2] = 1; pv_s[1][2] = 1; wr_s[2][2] = 1; rd_s[3][3] = 1; wr_s[3][3] = 1;
        cfg_wr(12'h204, 32'h1, 1);
        cfg_wr(12'hA08, 32'h1, 1);
        cfg_wr(12'h10C, 32'h1, 1);
        cfg_wr(12'hA0C, 32'h1, 1);
        cfg_wr(12'h828, 32'h4, 1);
        cfg_wr(12'h820, 32'h4, 1);
        cfg_wr(12'h850, 32'h4, 1);
        cfg_wr(12'h868, 32'h8, 1);
        cfg_wr(12'h870, 32'h8, 1);
        cfg_rd(12'h868, 1, d); chk("R3 rdmap readback", d, 32'h8);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [AW-1:0] a;
            logic ok;
            a = {VEC[i][5:1], 12'h000} + AW'(i * 16);
            ok = VEC[i][0];
            access(VEC[i][11:9], VEC[i][8], VEC[i][7], VEC[i][6], a, e, rd, mr);
            chk(vec_tag(i), {31'b0, e}, {31'b0, !ok});
            chk("R6 rdata", rd, ok ? MEMV : 32'h0);
            chk("R6 mem_req", {31'b0, mr}, {31'b0, ok});
        end

        // R7: first denial (vector 1) captured
        cfg_rd(12'h008, 1, d); chk("R7 status", d, 32'h2);
        cfg_rd(12'h024, 1, d); chk("R7 fault addr", d, 32'h10);
        cfg_rd(12'h020, 1, d); chk("R7 attr", d, 32'h02);
        chk("R8 irq high", {31'b0, irq}, 32'h1);
        cfg_wr(12'h00C, 32'h2, 1);
        cfg_rd(12'h008, 1, d); chk("R8 status cleared", d, 32'h0);
        chk("R8 irq cleared", {31'b0, irq}, 32'h0);
        access(3'd5, 0, 1, 1, 17'h01044, e, rd, mr);
        chk("R6 write dropped", {31'b0, mr}, 32'h0);
        access(3'd0, 1, 0, 0, 17'h00020, e, rd, mr);
        cfg_rd(12'h024, 1, d); chk("R7 held addr", d, 32'h1044);
        cfg_rd(12'h020, 1, d); chk("R7 held attr", d, 32'h55);
        cfg_wr(12'h00C, 32'h2, 1);

        // R2: secure to non-secure
        cfg_wr(12'h000, 32'h8000_0000, 1);
        srw = 1;
        access(3'd0, 1, 0, 0, 17'h00040, e, rd, mr);
        chk("R2 secure to ns", {31'b0, e}, 32'h0);
        access(3'd0, 0, 1, 0, 17'h01040, e, rd, mr);
        chk("R2 ns to secure", {31'b0, e}, 32'h1);

        // random mix against model
        for (int i = 0; i < 300; i++) begin
            int pg, c;
            bit s, p, w, ok;
            pg = $urandom_range(0, 5);
            c = $urandom_range(0, 7);
            s = 1'($urandom); p = 1'($urandom); w = 1'($urandom);
            ok = model_ok(c, s, p, w, pg);
            access(3'(c), s, p, w, {5'(pg), 12'h100}, e, rd, mr);
            chk("R1 R3 R4 random", {31'b0, e}, {31'b0, !ok});
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule